// File: doc/BRIEF.md
# Vector Instruction Chaining Issue Controller

This block sits in front of a small vector machine and decides, every clock, whether the instruction at its input may start. The machine has a bank of vector registers and a few pipelined functional units, for example an adder and a multiplier. The block keeps a record for each unit: whether it is busy, how many result elements it still owes, its vector length, and the registers it writes and reads. From these records it finds unit conflicts, register conflicts and read-after-write dependences.

A dependent instruction can start in two ways. The first is chained issue: its operand stream is taken directly from the producing unit. This is allowed only in the cycle in which the producer writes its first result element, and only if both instructions have the same length. The second is plain issue after the producer has finished and its registers are free again. In every other case the instruction waits. The block grants at most one instruction per cycle, in program order. A waiting instruction stays at the input with `in_ready` low. The chain outputs tell the datapath which unit feeds each operand, so that unit's elements can be routed to the consumer in the same cycle they are written.

Top module: `vec_chain_issue`

## Requirements
- R1: After reset every unit is idle (`unit_busy` all zero), and with `in_valid` low `in_ready`, `chain_a`, `chain_b` and `unit_done` stay low.
- R2: An instruction is not granted while its target unit (`in_unit`, a unit index) is busy, or if the index is not below NFU.
- R3: An instruction is not granted while any busy unit writes its destination register, reads its destination register, or reads either of its source registers.
- R4: If a source register (`in_src_a` or `in_src_b`) is the destination of a busy unit, the grant depends on that unit. The unit must assert `elem_wr` while it still owes its full length, which is its first element. Its vector length must also equal `in_len`. When both hold and no other conflict exists, `in_ready` rises in that same cycle. The matching `chain_a` or `chain_b` rises, and `chain_a_unit` or `chain_b_unit` carries the producer's unit index.
- R5: If a read-after-write dependence misses the producer's first-element cycle, the instruction waits. It is granted, without chaining, in the cycle after the producer's last element.
- R6: If the vector lengths differ, no chain is formed and the dependent instruction waits until the producer is released, as in R5.
- R7: A busy unit counts down one element for each cycle with `elem_wr` set. `unit_done` pulses in the cycle of its last element, and `unit_busy` clears in the next cycle. `elem_wr` to an idle unit has no effect.
- R8: `in_ready` is decided in the same cycle from the current inputs. A granted instruction makes its unit show busy from the next cycle. At most one instruction is granted per cycle.
- R9: Vector lengths must be between 1 and MAXVL. An instruction with `in_len` of 0 or above MAXVL is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present at the input |
| in_unit | input | FUW | Functional unit index the instruction needs |
| in_dst | input | RW | Destination vector register |
| in_src_a | input | RW | First source vector register |
| in_src_b | input | RW | Second source vector register |
| in_len | input | VLW | Vector length, 1..MAXVL |
| elem_wr | input | NFU | Per-unit result element written this cycle |
| in_ready | output | 1 | Instruction granted this cycle |
| chain_a | output | 1 | Operand A chained from a producer unit |
| chain_b | output | 1 | Operand B chained from a producer unit |
| chain_a_unit | output | FUW | Producer unit feeding operand A |
| chain_b_unit | output | FUW | Producer unit feeding operand B |
| unit_done | output | NFU | Per-unit last element written this cycle |
| unit_busy | output | NFU | Per-unit busy flags |

## Verification
The bench builds the block with two functional units and a maximum vector length of 8. With these values a one-cycle chaining window and a length mismatch come up within a few clocks of each other. The register file keeps all eight registers, so unit conflicts and register conflicts show up often in a long sweep that is almost random, with lengths of one to three elements. An arithmetic model in the bench predicts every output in every cycle. Short directed sequences cover these cases:
- a chain taken in the first-element cycle
- a missed chain window
- a length mismatch
- a busy unit
- a write-after-read conflict
- lengths at 0, MAXVL and MAXVL+1

// File: rtl/vec_chain_issue.sv
module vec_chain_issue #(
  parameter int NREG  = 8,
  parameter int NFU   = 3,
  parameter int MAXVL = 64,
  localparam int RW   = $clog2(NREG),
  localparam int FUW  = (NFU > 1) ? $clog2(NFU) : 1,
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [FUW-1:0] in_unit,
  input  logic [RW-1:0]  in_dst,
  input  logic [RW-1:0]  in_src_a,
  input  logic [RW-1:0]  in_src_b,
  input  logic [VLW-1:0] in_len,
  input  logic [NFU-1:0] elem_wr,
  output logic           in_ready,
  output logic           chain_a,
  output logic           chain_b,
  output logic [FUW-1:0] chain_a_unit,
  output logic [FUW-1:0] chain_b_unit,
  output logic [NFU-1:0] unit_done,
  output logic [NFU-1:0] unit_busy
);

  logic [NFU-1:0] busy_q;
  logic [VLW-1:0] cnt_q [NFU];
  logic [VLW-1:0] len_q [NFU];
  logic [RW-1:0]  dst_q [NFU];
  logic [RW-1:0]  sa_q  [NFU];
  logic [RW-1:0]  sb_q  [NFU];

  logic hard, blk, ca, cb, unit_ok, len_ok;
  logic [FUW-1:0] cau, cbu;

  assign unit_busy = busy_q;
  assign len_ok    = (in_len != '0) && (int'(in_len) <= MAXVL);
  assign unit_ok   = (int'(in_unit) < NFU) && !busy_q[in_unit];

  always_comb begin
    hard = 1'b0;
    blk  = 1'b0;
    ca   = 1'b0;
    cb   = 1'b0;
    cau  = '0;
    cbu  = '0;
    for (int u = 0; u < NFU; u++) begin
      if (busy_q[u]) begin
        if (dst_q[u] == in_dst || sa_q[u] == in_dst || sb_q[u] == in_dst)
          hard = 1'b1;
        if (sa_q[u] == in_src_a || sb_q[u] == in_src_a ||
            sa_q[u] == in_src_b || sb_q[u] == in_src_b)
          hard = 1'b1;
        if (dst_q[u] == in_src_a) begin
          if (elem_wr[u] && cnt_q[u] == len_q[u] && len_q[u] == in_len) begin
            ca  = 1'b1;
            cau = FUW'(u);
          end else blk = 1'b1;
        end
        if (dst_q[u] == in_src_b) begin
          if (elem_wr[u] && cnt_q[u] == len_q[u] && len_q[u] == in_len) begin
            cb  = 1'b1;
            cbu = FUW'(u);
          end else blk = 1'b1;
        end
      end
    end
  end

  assign in_ready     = rst_n && in_valid && unit_ok && len_ok && !hard && !blk;
  assign chain_a      = in_ready && ca;
  assign chain_b      = in_ready && cb;
  assign chain_a_unit = cau;
  assign chain_b_unit = cbu;

  always_comb
    for (int u = 0; u < NFU; u++)
      unit_done[u] = busy_q[u] && elem_wr[u] && cnt_q[u] == VLW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      for (int u = 0; u < NFU; u++) begin
        cnt_q[u] <= '0;
        len_q[u] <= '0;
        dst_q[u] <= '0;
        sa_q[u]  <= '0;
        sb_q[u]  <= '0;
      end
    end else begin
      for (int u = 0; u < NFU; u++) begin
        if (busy_q[u] && elem_wr[u]) begin
          cnt_q[u] <= cnt_q[u] - VLW'(1);
          if (cnt_q[u] == VLW'(1)) busy_q[u] <= 1'b0;
        end
        if (in_ready && int'(in_unit) == u) begin
          busy_q[u] <= 1'b1;
          cnt_q[u]  <= in_len;
          len_q[u]  <= in_len;
          dst_q[u]  <= in_dst;
          sa_q[u]   <= in_src_a;
          sb_q[u]   <= in_src_b;
        end
      end
    end
  end

  // R8
  issue_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> unit_busy[$past(in_unit)]);

  // R2
  free_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !unit_busy[in_unit]);

  // R4
  chain_a_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_a |-> (in_ready && elem_wr[chain_a_unit] && unit_busy[chain_a_unit]));

  // R4
  chain_b_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_b |-> (in_ready && elem_wr[chain_b_unit] && unit_busy[chain_b_unit]));

  // R9
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (in_len != '0 && int'(in_len) <= MAXVL));

  generate
    for (genvar g = 0; g < NFU; g++) begin : g_unit_chk
      // R7
      done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unit_done[g] |=> !unit_busy[g]);
      // R7
      idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_busy[g] |-> !unit_done[g]);
    end
  endgenerate

endmodule

// File: tb/vec_chain_issue_bench.sv
module vec_chain_issue_bench;
  localparam int NFU = 2, MAXVL = 8, RW = 3, FUW = 1, VLW = 4;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0;
  logic [FUW-1:0] in_unit = '0;
  logic [RW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic [VLW-1:0] in_len = '0;
  logic [NFU-1:0] elem_wr = '0;
  logic in_ready, chain_a, chain_b;
  logic [FUW-1:0] chain_a_unit, chain_b_unit;
  logic [NFU-1:0] unit_done, unit_busy;

  vec_chain_issue #(.NREG(8), .NFU(NFU), .MAXVL(MAXVL)) u_vec_chain_issue (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b), .in_len(in_len),
    .elem_wr(elem_wr), .in_ready(in_ready), .chain_a(chain_a), .chain_b(chain_b),
    .chain_a_unit(chain_a_unit), .chain_b_unit(chain_b_unit),
    .unit_done(unit_done), .unit_busy(unit_busy));

  always #10 clk = ~clk;

  int nvec = 0, nbad = 0;
  bit mb [NFU];
  int mc [NFU], mv [NFU], md [NFU], ms1 [NFU], ms2 [NFU];
  logic s_rdy, s_ca, s_cb;
  logic [NFU-1:0] s_done;

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit v, input int fu, input int d,
                      input int s1, input int s2, input int vl, input int wr);
    bit hard, blk, ch1, ch2, rdy;
    int c1u, c2u;
    logic [NFU-1:0] edone, ebusy;
    @(negedge clk);
    in_valid = v; in_unit = FUW'(fu); in_dst = RW'(d); in_src_a = RW'(s1);
    in_src_b = RW'(s2); in_len = VLW'(vl); elem_wr = NFU'(wr);
    #5;
    hard = 0; blk = 0; ch1 = 0; ch2 = 0; c1u = 0; c2u = 0;
    for (int u = 0; u < NFU; u++) begin
      edone[u] = mb[u] && wr[u] && mc[u] == 1;
      ebusy[u] = mb[u];
      if (mb[u]) begin
        bit link;
        link = wr[u] && mc[u] == mv[u] && mv[u] == vl;
        if (md[u] == d || ms1[u] == d || ms2[u] == d) hard = 1;
        if (ms1[u] == s1 || ms2[u] == s1 || ms1[u] == s2 || ms2[u] == s2) hard = 1;
        if (md[u] == s1) begin if (link) begin ch1 = 1; c1u = u; end else blk = 1; end
        if (md[u] == s2) begin if (link) begin ch2 = 1; c2u = u; end else blk = 1; end
      end
    end
    rdy = v && fu < NFU && !mb[fu] && vl >= 1 && vl <= MAXVL && !hard && !blk;
    s_rdy = in_ready; s_ca = chain_a; s_cb = chain_b; s_done = unit_done;
    chk({tag, " ready"}, int'(in_ready), int'(rdy));
    chk({tag, " chain"}, int'({chain_a, chain_b}), int'({rdy && ch1, rdy && ch2}));
    if (rdy && ch1) chk({tag, " chain_a_unit"}, int'(chain_a_unit), c1u);
    if (rdy && ch2) chk({tag, " chain_b_unit"}, int'(chain_b_unit), c2u);
    chk({tag, " done"}, int'(unit_done), int'(edone));
    chk({tag, " busy"}, int'(unit_busy), int'(ebusy));
    for (int u = 0; u < NFU; u++) begin
      if (mb[u] && wr[u]) begin
        if (mc[u] == 1) mb[u] = 0;
        mc[u]--;
      end
      if (rdy && fu == u) begin
        mb[u] = 1; mc[u] = vl; mv[u] = vl; md[u] = d; ms1[u] = s1; ms2[u] = s2;
      end
    end
  endtask

  task automatic drain(input string tag, input int n, input int wr);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 1, wr);
  endtask

  initial begin
    #(20 * 150000);
    nbad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int pv, pf, pd, p1, p2, pl;
    for (int u = 0; u < NFU; u++) begin mb[u] = 0; mc[u] = 0; mv[u] = 0; md[u] = 0; ms1[u] = 0; ms2[u] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    step("R1", 0, 0, 1, 2, 3, 4, 0);
    chk("R1 idle ready", int'(s_rdy), 0);
    // R7 idle unit ignores element writes
    step("R7", 0, 0, 1, 2, 3, 4, 3);
    chk("R7 idle done", int'(s_done), 0);
    // R4 chain in first-element cycle
    step("R4", 1, 0, 1, 2, 3, 4, 0);
    chk("R4 producer issue", int'(s_rdy), 1);
    step("R4", 1, 1, 4, 1, 5, 4, 0);
    chk("R4 wait before first element", int'(s_rdy), 0);
    step("R4", 1, 1, 4, 1, 5, 4, 1);
    chk("R4 chained issue", int'(s_rdy & s_ca), 1);
    drain("R7", 4, 3);
    // R5 missed window
    step("R5", 1, 0, 1, 2, 3, 3, 0);
    step("R5", 0, 0, 0, 0, 0, 1, 1);
    step("R5", 1, 1, 4, 1, 5, 3, 1);
    chk("R5 missed window stalls", int'(s_rdy), 0);
    step("R5", 1, 1, 4, 1, 5, 3, 1);
    chk("R5 producer done", int'(s_done), 1);
    step("R5", 1, 1, 4, 1, 5, 3, 0);
    chk("R5 issue after release", int'({s_rdy, s_ca}), 2);
    drain("R5", 3, 2);
    // R6 length mismatch
    step("R6", 1, 0, 1, 2, 3, 3, 0);
    step("R6", 1, 1, 4, 1, 5, 5, 1);
    chk("R6 no chain on mismatch", int'(s_rdy), 0);
    step("R6", 1, 1, 4, 1, 5, 5, 1);
    step("R6", 1, 1, 4, 1, 5, 5, 1);
    step("R6", 1, 1, 4, 1, 5, 5, 0);
    chk("R6 issue after release", int'({s_rdy, s_ca}), 2);
    drain("R6", 5, 2);
    // R2 unit busy
    step("R2", 1, 0, 1, 2, 3, 2, 0);
    step("R2", 1, 0, 6, 7, 7, 2, 0);
    chk("R2 busy unit stalls", int'(s_rdy), 0);
    step("R2", 1, 0, 6, 7, 7, 2, 1);
    step("R2", 1, 0, 6, 7, 7, 2, 1);
    step("R2", 1, 0, 6, 7, 7, 2, 0);
    chk("R2 free unit grants", int'(s_rdy), 1);
    drain("R2", 2, 1);
    // R3 write-after-read
    step("R3", 1, 0, 1, 2, 3, 2, 0);
    step("R3", 1, 1, 2, 5, 6, 2, 1);
    chk("R3 WAR stalls", int'(s_rdy), 0);
    step("R3", 1, 1, 2, 5, 6, 2, 1);
    step("R3", 1, 1, 2, 5, 6, 2, 0);
    chk("R3 grant after release", int'(s_rdy), 1);
    drain("R3", 2, 2);
    // R9 length range
    step("R9", 1, 0, 1, 2, 3, 0, 0);
    chk("R9 zero length", int'(s_rdy), 0);
    step("R9", 1, 0, 1, 2, 3, 9, 0);
    chk("R9 over max", int'(s_rdy), 0);
    step("R9", 1, 0, 1, 2, 3, 8, 0);
    chk("R9 max length", int'(s_rdy), 1);
    drain("R9", 8, 1);
    // R8 sweep: held instructions in program order
    pv = 0; pf = 0; pd = 0; p1 = 0; p2 = 0; pl = 1;
    for (int i = 0; i < 4000; i++) begin
      if (!pv || s_rdy) begin
        pv = ($urandom % 5) != 0;
        pf = $urandom % 2; pd = $urandom % 8; p1 = $urandom % 8; p2 = $urandom % 8;
        pl = (($urandom % 16) == 0) ? ($urandom % 10) : 1 + ($urandom % 3);
      end
      step("R8", pv, pf, pd, p1, p2, pl, $urandom % 4);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule